// File: doc/BRIEF.md
# Colour Lookup Table with Per-Channel 16bpp Indexing

This block is a 256-entry colour palette. Each entry holds three 8-bit channels: red, green and blue. The palette is loaded through a 32-bit write port. A pointer-load command picks the starting entry. Each data command after it stores one entry and moves the pointer on by one, so software can stream a whole table without re-addressing.

On the pixel side, a pixel code and a depth mode go in, and a 24-bit RGB value comes out one clock later.
- At 1, 2, 4 and 8 bits per pixel, one index selects the same entry for all three channels.
- At 16 bits per pixel, each channel is looked up with its own 8-bit field of the pixel. The fields overlap, so the table acts as three independent channel tables.
- At 32 bits per pixel, each channel byte of the pixel is passed through its own channel table, which works as a per-channel gamma map.

Top module: `colour_lut`

## Requirements
- R1: While `rst` is high, `rgb_out` is 0 and the write pointer returns to entry 0. After reset, the first data write lands in entry 0.
- R2: A write with bits 31:28 = 4'h1 and bits 27:24 = 0 sets the write pointer to bits 7:0 of the word.
- R3: A write with bits 31:24 = 8'h00 stores red = bits 7:0, green = bits 15:8 and blue = bits 23:16 at the pointer. The pointer then increases by one.
- R4: A data write at entry 255 moves the pointer to entry 0.
- R5: A write with any other value in bits 31:24 changes neither the table nor the pointer.
- R6: Modes 0, 1 and 2 (1, 2 and 4 bpp) use the low 1, 2 or 4 pixel bits as the index for all channels. The upper index bits are zero.
- R7: Mode 3 (8 bpp) uses pixel bits 7:0 as the index for all channels. Modes 6 and 7 behave as mode 3.
- R8: Mode 4 (16 bpp) takes red from the entry at pixel bits 7:0, green from the entry at bits 11:4 and blue from the entry at bits 15:8. Each lookup reads only its own channel.
- R9: Mode 5 (32 bpp) takes red from the entry at pixel bits 7:0, green from the entry at bits 15:8 and blue from the entry at bits 23:16.
- R10: `rgb_out` (red 7:0, green 15:8, blue 23:16) reflects the pixel and mode present at the previous rising clock edge.
- R11: If an entry is written and read in the same cycle, the read returns the value the entry held before that write.
- R12: If entry i holds red of colour i&31, green of colour (i>>1)&31 and blue of colour (i>>2)&31, then a mode 4 pixel with fields red 4:0, green 9:5 and blue 14:10 returns the three channels of the matching colours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the write port and the lookup |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for `wr_word` |
| wr_word | input | 32 | Command nibble 31:28, reserved bits 27:24, payload 23:0 |
| mode | input | 3 | Pixel depth: 0=1, 1=2, 2=4, 3=8, 4=16, 5=32 bpp |
| pix | input | 24 | Pixel code |
| rgb_out | output | 24 | Looked-up colour: red 7:0, green 15:8, blue 23:16 |

## Verification
The hardest case to reach from the ports is the 16 bpp mapping.

The overlapping fields only show a correct result when every one of the 256 entries holds a different colour in each channel. The bench therefore streams a full table from pointer 0, built with the shifted-by-one and shifted-by-two channel pattern. It then sends random 15-bit pixels and compares the result against the logical colour table directly.

The same-cycle write and read, and the 255-to-0 pointer wrap, are reached by loading the pointer first. The bench then places a data write and a lookup of the same entry on one clock edge.

// File: rtl/clut_pkg.sv
package clut_pkg;

    localparam int CH_W    = 8;
    localparam int IDX_W   = 8;
    localparam int ENTRIES = 1 << IDX_W;
    localparam int NCH     = 3;
    localparam int CMD_W   = 4;
    localparam int RGB_W   = NCH * CH_W;
    localparam int WORD_W  = 2 * CMD_W + RGB_W;
    localparam int PIX_W   = RGB_W;
    localparam int MODE_W  = 3;

    typedef logic [CH_W-1:0]  chan_t;
    typedef logic [IDX_W-1:0] idx_t;

    // red in the low byte, blue in the high byte
    typedef struct packed {
        chan_t b;
        chan_t g;
        chan_t r;
    } rgb_t;

    typedef struct packed {
        idx_t b;
        idx_t g;
        idx_t r;
    } idx3_t;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [CMD_W-1:0] rsvd;
        rgb_t             payload;
    } wr_word_t;

    typedef enum logic [CMD_W-1:0] {
        CMD_DATA = 4'h0,
        CMD_PTR  = 4'h1
    } cmd_e;

    typedef enum logic [MODE_W-1:0] {
        BPP1  = 3'd0,
        BPP2  = 3'd1,
        BPP4  = 3'd2,
        BPP8  = 3'd3,
        BPP16 = 3'd4,
        BPP32 = 3'd5
    } depth_e;

    function automatic idx_t keep_low(input idx_t v, input int n);
        idx_t m;
        m = idx_t'((1 << n) - 1);
        return v & m;
    endfunction

endpackage

// File: rtl/clut_wr_port.sv
module clut_wr_port
    import clut_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output logic              we,
    output idx_t              waddr,
    output rgb_t              wdata
);
    wr_word_t w;
    logic     legal;
    logic     ld;
    idx_t     ptr;

    assign w     = wr_word_t'(wr_word);
    assign legal = wr_en && (w.rsvd == '0);
    assign we    = legal && (w.cmd == CMD_DATA);
    assign ld    = legal && (w.cmd == CMD_PTR);
    assign wdata = w.payload;
    assign waddr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (ld) begin
            ptr <= w.payload.r;
        end else if (we) begin
            ptr <= ptr + 1'b1;
        end
    end

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_word[31:28] == 4'h1 && wr_word[27:24] == 4'h0)
        |=> (ptr == $past(wr_word[7:0]))); // R2

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_word[31:24] == 8'h00)
        |=> (ptr == idx_t'($past(ptr) + 1))); // R3

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_word[31:24] == 8'h00 && ptr == '1)
        |=> (ptr == '0)); // R4

    AST_PTR_IGNORE: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (wr_word[31:24] == 8'h00 || wr_word[31:24] == 8'h10))
        |=> $stable(ptr)); // R5

endmodule

// File: rtl/clut_idx_sel.sv
module clut_idx_sel
    import clut_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic [PIX_W-1:0]  pix,
    output idx3_t             idx
);
    idx_t base;

    assign base = pix[IDX_W-1:0];

    always_comb begin
        idx = '0;
        case (mode)
            BPP1: begin
                idx.r = keep_low(base, 1);
                idx.g = idx.r;
                idx.b = idx.r;
            end
            BPP2: begin
                idx.r = keep_low(base, 2);
                idx.g = idx.r;
                idx.b = idx.r;
            end
            BPP4: begin
                idx.r = keep_low(base, 4);
                idx.g = idx.r;
                idx.b = idx.r;
            end
            BPP16: begin
                idx.r = pix[7:0];
                idx.g = pix[11:4];
                idx.b = pix[15:8];
            end
            BPP32: begin
                idx.r = pix[7:0];
                idx.g = pix[15:8];
                idx.b = pix[23:16];
            end
            default: begin
                idx.r = base;
                idx.g = base;
                idx.b = base;
            end
        endcase
    end

    AST_NARROW_IDX: assert property (@(posedge clk) disable iff (rst)
        (mode == BPP1 || mode == BPP2 || mode == BPP4)
        |-> (idx.r[7:4] == 4'h0 && idx.g == idx.r && idx.b == idx.r)); // R6

endmodule

// File: rtl/clut_bank.sv
module clut_bank
    import clut_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  idx_t  waddr,
    input  rgb_t  wdata,
    input  idx3_t ridx,
    output rgb_t  rdata
);
    logic [NCH-1:0][CH_W-1:0]  wd;
    logic [NCH-1:0][IDX_W-1:0] ra;
    logic [NCH-1:0][CH_W-1:0]  rq;

    assign wd    = wdata;
    assign ra    = ridx;
    assign rdata = rgb_t'(rq);

    // one storage array per channel so each channel reads its own index
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chan_t mem [ENTRIES];
        chan_t q;

        always_ff @(posedge clk) begin
            if (we) begin
                mem[waddr] <= wd[c];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else begin
                q <= mem[ra[c]];
            end
        end

        assign rq[c] = q;
    end

endmodule

// File: rtl/colour_lut.sv
module colour_lut
    import clut_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [MODE_W-1:0] mode,
    input  logic [PIX_W-1:0]  pix,
    output logic [RGB_W-1:0]  rgb_out
);
    logic  we;
    idx_t  waddr;
    rgb_t  wdata;
    idx3_t ridx;
    rgb_t  rdata;

    clut_wr_port i_wr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata)
    );

    clut_idx_sel i_sel (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .pix  (pix),
        .idx  (ridx)
    );

    clut_bank i_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .ridx  (ridx),
        .rdata (rdata)
    );

    assign rgb_out = rdata;

    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (rgb_out == '0)); // R1

endmodule

// File: tb/test_colour_lut.sv
module test_colour_lut;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_word = '0;
    logic [2:0]  mode = 3'd3;
    logic [23:0] pix = '0;
    logic [23:0] rgb_out;

    int checks = 0;
    int errors = 0;
    string phase = "R1";
    bit running = 1'b0;

    colour_lut i_colour_lut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .mode    (mode),
        .pix     (pix),
        .rgb_out (rgb_out)
    );

    always #10 clk = ~clk;

    // behavioural reference model
    logic [7:0]  mr [256];
    logic [7:0]  mg [256];
    logic [7:0]  mb [256];
    bit          known [256];
    int          mptr = 0;
    logic [23:0] exp_rgb = '0;
    bit          exp_ok = 1'b0;

    always @(posedge clk) begin
        int ir, ig, ib;
        if (rst) begin
            exp_rgb = '0;
            exp_ok  = 1'b1;
            mptr    = 0;
        end else begin
            ir = pix[7:0];
            ig = pix[7:0];
            ib = pix[7:0];
            case (mode)
                3'd0: begin ir = pix[0];   ig = ir; ib = ir; end
                3'd1: begin ir = pix[1:0]; ig = ir; ib = ir; end
                3'd2: begin ir = pix[3:0]; ig = ir; ib = ir; end
                3'd4: begin ir = pix[7:0]; ig = pix[11:4]; ib = pix[15:8]; end
                3'd5: begin ir = pix[7:0]; ig = pix[15:8]; ib = pix[23:16]; end
                default: ;
            endcase
            exp_ok  = known[ir] && known[ig] && known[ib];
            exp_rgb = {mb[ib], mg[ig], mr[ir]};
            if (wr_en) begin
                if (wr_word[31:24] == 8'h10) begin
                    mptr = wr_word[7:0];
                end else if (wr_word[31:24] == 8'h00) begin
                    mr[mptr] = wr_word[7:0];
                    mg[mptr] = wr_word[15:8];
                    mb[mptr] = wr_word[23:16];
                    known[mptr] = 1'b1;
                    mptr = (mptr + 1) % 256;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [23:0] act, input logic [23:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %06h expected %06h at %0t", tag, act, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        if (running && !rst && exp_ok) begin
            check(rgb_out === exp_rgb, phase, rgb_out, exp_rgb);
        end
    end

    task automatic wr(input logic [31:0] w);
        wr_en   = 1'b1;
        wr_word = w;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_word = '0;
    endtask

    task automatic px(input logic [2:0] m, input logic [23:0] p);
        mode = m;
        pix  = p;
        @(negedge clk);
    endtask

    function automatic logic [23:0] pat(input int i);
        logic [7:0] v;
        v = 8'(i);
        return {8'(i * 3 + 17), ~v, v};
    endfunction

    logic [7:0] cr [32];
    logic [7:0] cg [32];
    logic [7:0] cb [32];

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) known[i] = 1'b0;
        repeat (3) @(negedge clk);
        check(rgb_out === 24'h0, "R1 reset output", rgb_out, 24'h0);
        rst = 1'b0;
        running = 1'b1;

        // R1: first data write after reset lands in entry 0
        phase = "R1";
        wr(32'h00ABCDEF);
        px(3'd3, 24'h0);
        check(rgb_out === 24'hABCDEF, "R1 first write at entry 0", rgb_out, 24'hABCDEF);

        // R3: stream the whole table from pointer 0
        phase = "R3";
        wr(32'h10000000);
        for (int i = 0; i < 256; i++) wr({8'h00, pat(i)});
        px(3'd3, 24'h000007);
        check(rgb_out === pat(7), "R3 entry 7", rgb_out, pat(7));
        px(3'd3, 24'h0000C8);
        check(rgb_out === pat(200), "R7 entry 200", rgb_out, pat(200));

        // R10: one-cycle latency
        phase = "R10";
        px(3'd3, 24'h000005);
        pix = 24'h000009;
        #1;
        check(rgb_out === pat(5), "R10 output unchanged before edge", rgb_out, pat(5));
        @(negedge clk);
        check(rgb_out === pat(9), "R10 output after one edge", rgb_out, pat(9));

        // R11: same-cycle write and read of entry 0x20
        phase = "R11";
        wr(32'h10000020);
        mode = 3'd3;
        pix = 24'h000020;
        wr_en = 1'b1;
        wr_word = 32'h00123456;
        @(negedge clk);
        wr_en = 1'b0;
        wr_word = '0;
        check(rgb_out === pat(32), "R11 old value on collision", rgb_out, pat(32));
        @(negedge clk);
        check(rgb_out === 24'h123456, "R11 new value next cycle", rgb_out, 24'h123456);

        // R4: wrap from 255 to 0
        phase = "R4";
        wr(32'h100000FF);
        wr(32'h00111111);
        wr(32'h00222222);
        px(3'd3, 24'h0000FF);
        check(rgb_out === 24'h111111, "R4 entry 255", rgb_out, 24'h111111);
        px(3'd3, 24'h000000);
        check(rgb_out === 24'h222222, "R4 wrapped to entry 0", rgb_out, 24'h222222);

        // R2: pointer load
        phase = "R2";
        wr(32'h1FFFFF12);
        px(3'd3, 24'h000012);
        wr(32'h10ABCD12);
        wr(32'h00445566);
        px(3'd3, 24'h000012);
        check(rgb_out === 24'h445566, "R2 pointer loaded from low byte", rgb_out, 24'h445566);

        // R5: illegal commands ignored
        phase = "R5";
        wr(32'h10000040);
        wr(32'h2AAAAAAA);
        wr(32'hF0000012);
        wr(32'h01777777);
        wr(32'h11000013);
        wr(32'h00999999);
        px(3'd3, 24'h000040);
        check(rgb_out === 24'h999999, "R5 pointer kept after ignored writes", rgb_out, 24'h999999);
        px(3'd3, 24'h000012);
        check(rgb_out === 24'h445566, "R5 entry 0x12 untouched", rgb_out, 24'h445566);
        px(3'd3, 24'h000041);
        check(rgb_out === pat(65), "R5 entry 0x41 untouched", rgb_out, pat(65));

        // depth sweeps, checked every cycle by the model
        phase = "R6";
        for (int k = 0; k < 3; k++) begin
            for (int n = 0; n < 60; n++) px(3'(k), 24'($urandom));
        end
        px(3'd2, 24'hFFFFF3);
        check(rgb_out === pat(3), "R6 4bpp uses low nibble", rgb_out, pat(3));
        phase = "R7";
        for (int n = 0; n < 60; n++) px(3'd3, 24'($urandom));
        for (int n = 0; n < 30; n++) px(3'd6, 24'($urandom));
        for (int n = 0; n < 30; n++) px(3'd7, 24'($urandom));
        phase = "R8";
        for (int n = 0; n < 100; n++) px(3'd4, 24'($urandom));
        px(3'd4, 24'h00C8A5);
        check(rgb_out === {pat(200)[23:16], pat(138)[15:8], pat(165)[7:0]},
              "R8 split indices", rgb_out,
              {pat(200)[23:16], pat(138)[15:8], pat(165)[7:0]});
        phase = "R9";
        for (int n = 0; n < 100; n++) px(3'd5, 24'($urandom));
        px(3'd5, 24'hC86407);
        check(rgb_out === {pat(200)[23:16], pat(100)[15:8], pat(7)[7:0]},
              "R9 byte indices", rgb_out,
              {pat(200)[23:16], pat(100)[15:8], pat(7)[7:0]});

        // mixed random traffic including illegal commands
        phase = "R5";
        for (int n = 0; n < 800; n++) begin
            int sel;
            sel = $urandom_range(0, 3);
            mode = 3'($urandom);
            pix  = 24'($urandom);
            wr_en = ($urandom_range(0, 1) == 1);
            case (sel)
                0: wr_word = {8'h00, 24'($urandom)};
                1: wr_word = {8'h10, 24'($urandom)};
                default: wr_word = $urandom;
            endcase
            @(negedge clk);
        end
        wr_en = 1'b0;

        // R12: 5-5-5 pattern
        phase = "R12";
        for (int k = 0; k < 32; k++) begin
            cr[k] = 8'(k * 8 + 1);
            cg[k] = 8'(255 - k * 5);
            cb[k] = 8'(k * 3 + 100);
        end
        wr(32'h10000000);
        for (int i = 0; i < 256; i++)
            wr({8'h00, cb[(i >> 2) & 31], cg[(i >> 1) & 31], cr[i & 31]});
        for (int n = 0; n < 40; n++) begin
            logic [14:0] p;
            logic [23:0] e;
            p = 15'($urandom);
            e = {cb[p[14:10]], cg[p[9:5]], cr[p[4:0]]};
            px(3'd4, {9'h0, p});
            check(rgb_out === e, "R12 5-5-5 colour", rgb_out, e);
        end

        running = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule